// File: doc/BRIEF.md
# Parallel Flash Pin Interface Front End

This block sits between the asynchronous control pins of a parallel NOR-style flash and its internal logic. On every clock it classifies the pin levels as one bus operation (standby, read, write, output disable or hardware reset). For reads it drives the 16-bit data bus, in either word or byte width. It also detects the end of each write strobe and hands the captured address and data to a downstream command interpreter.

In byte width the top data pin stops carrying data and becomes the lowest byte-address bit. That bit picks which half of the addressed word appears on the low eight lanes, and the seven middle lanes stay tri-stated. A small command register starts in read-array mode and follows the low byte of each completed write. A write-protect pin marks writes to the outer sectors as protected. Which outer sectors count is fixed by a parameter.

All pins are sampled on the system clock. Lane enables, read data and the operation code are registered, so each appears one clock after the pin levels that caused it. The array address passes straight through from the address pins, so a combinational array can answer within the same cycle.

Top module: `flash_fe`

## Requirements
- R1: While `hw_rst_n` is sampled low, the next cycle shows `bus_op` = 4 (reset) with all three lane enables low, whatever the other pins are.
- R2: With `hw_rst_n` high and `chip_en_n` sampled high, the next cycle shows `bus_op` = 0 (standby) with all lane enables low, whatever the other controls are.
- R3: With `chip_en_n` low, `out_en_n` low, `wr_en_n` high and `word_mode` high, the next cycle shows `bus_op` = 1 (read), all three lane enables high and `dq_out` equal to `arr_rdata`.
- R4: With `chip_en_n` low and `out_en_n` and `wr_en_n` both high, or both low, the next cycle shows `bus_op` = 3 (output disable) with all lane enables low.
- R5: A read with `word_mode` low raises only `lane_oe_lo`. `dq_out[7:0]` carries `arr_rdata[7:0]` when `dq_in[15]` is 0 and `arr_rdata[15:8]` when it is 1. `dq_out[15:8]` reads 0.
- R6: `chip_en_n` low, `wr_en_n` low and `out_en_n` high is a write (`bus_op` = 2). At the first edge that samples a non-write, non-reset state after one or more write cycles, `cmd_valid` rises for exactly one cycle. The address and data sampled on the last write cycle appear with it.
- R7: `cmd_addr` is a byte address: `{addr_in, 0}` in word mode and `{addr_in, dq_in[15]}` in byte mode. In byte mode `cmd_data` is `{8'h00, dq_in[7:0]}`.
- R8: The sector is `addr_in[19:16]`. `cmd_prot` is 1 with the pulse when `wr_prot_n` was low on the last write cycle and the sector is 0 or 15 (default setting). It is 0 otherwise, and always 0 outside a pulse.
- R9: `read_mode` is 1 after the synchronous reset and one cycle after `hw_rst_n` is sampled low. It changes together with the `cmd_valid` pulse: 1 if the low data byte was F0 hex, 0 for any other value.
- R10: If `hw_rst_n` is sampled low before the write strobe ends, no `cmd_valid` pulse is produced for that write.
- R11: During the synchronous reset `bus_op` is 0, all lane enables and `cmd_valid` are low, and `read_mode` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| chip_en_n | input | 1 | Chip enable pin, active low |
| out_en_n | input | 1 | Output enable pin, active low |
| wr_en_n | input | 1 | Write strobe pin, active low |
| hw_rst_n | input | 1 | Hardware reset pin, active low |
| wr_prot_n | input | 1 | Write protect pin, active low |
| word_mode | input | 1 | 1 = 16-bit bus, 0 = 8-bit bus |
| addr_in | input | 20 | Word address pins |
| dq_in | input | 16 | Input side of the data pins (bit 15 is the byte-address bit in byte mode) |
| arr_rdata | input | 16 | Word read from the array at `arr_addr` |
| arr_addr | output | 20 | Word address to the array |
| dq_out | output | 16 | Output side of the data pins |
| lane_oe_lo | output | 1 | Drive enable for data lanes 0-7 |
| lane_oe_mid | output | 1 | Drive enable for data lanes 8-14 |
| lane_oe_top | output | 1 | Drive enable for data lane 15 |
| bus_op | output | 3 | Decoded operation: 0 standby, 1 read, 2 write, 3 output disable, 4 reset |
| cmd_valid | output | 1 | One-cycle pulse at the end of a write strobe |
| cmd_addr | output | 21 | Byte address of the completed write |
| cmd_data | output | 16 | Data of the completed write |
| cmd_prot | output | 1 | Completed write targets a protected sector |
| read_mode | output | 1 | Command register holds the read-array command |

## Verification
Some rules are checked by the assertions on every clock: the tri-state rules for reset, standby and byte-width reads, word-mode read data following the array, the one-cycle width of the command pulse, the protected flag never appearing without the pulse, and reset restoring read-array mode and suppressing the pulse. Other behaviour needs the bench's scenarios. Byte-lane selection by the top data pin, the byte address and zero-filled data of byte writes, and the protected flag against specific sector and protect-pin values all depend on stimulus history. So does the command register following written values, and dropping a write that is cut short by the reset pin.

// File: rtl/flash_fe_pkg.sv
`timescale 1ns/1ps
package flash_fe_pkg;
  typedef enum logic [2:0] {
    OP_STANDBY = 3'd0,
    OP_READ    = 3'd1,
    OP_WRITE   = 3'd2,
    OP_ODIS    = 3'd3,
    OP_RESET   = 3'd4
  } bus_op_e;
endpackage

// File: rtl/flash_fe_decode.sv
`timescale 1ns/1ps
// Pin-level classification into one bus operation (combinational).
module flash_fe_decode
  import flash_fe_pkg::*;
(
  input  logic    chip_en_n,
  input  logic    out_en_n,
  input  logic    wr_en_n,
  input  logic    hw_rst_n,
  output bus_op_e op
);
  always_comb begin
    if (!hw_rst_n)                 op = OP_RESET;
    else if (chip_en_n)            op = OP_STANDBY;
    else if (!out_en_n && wr_en_n) op = OP_READ;
    else if (out_en_n && !wr_en_n) op = OP_WRITE;
    else                           op = OP_ODIS;  // both high, or contention
  end
endmodule

// File: rtl/flash_fe_lanes.sv
`timescale 1ns/1ps
// Registered read datapath: lane enables and word/byte steering.
module flash_fe_lanes
  import flash_fe_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  bus_op_e       op,
  input  logic          word_mode,
  input  logic          byte_hi,
  input  logic [DW-1:0] arr_rdata,
  output logic [DW-1:0] dq_out,
  output logic          oe_lo,
  output logic          oe_mid,
  output logic          oe_top
);
  localparam int HALF = DW / 2;

  logic          is_read;
  logic [DW-1:0] rd_next;

  assign is_read = (op == OP_READ);

  always_comb begin
    if (!is_read)       rd_next = '0;
    else if (word_mode) rd_next = arr_rdata;
    else if (byte_hi)   rd_next = {{(DW-HALF){1'b0}}, arr_rdata[DW-1:HALF]};
    else                rd_next = {{(DW-HALF){1'b0}}, arr_rdata[HALF-1:0]};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dq_out <= '0;
      oe_lo  <= 1'b0;
      oe_mid <= 1'b0;
      oe_top <= 1'b0;
    end else begin
      dq_out <= rd_next;
      oe_lo  <= is_read;
      oe_mid <= is_read && word_mode;
      oe_top <= is_read && word_mode;
    end
  end
endmodule

// File: rtl/flash_fe_wrcap.sv
`timescale 1ns/1ps
// Write strobe capture, end-of-strobe detection and sector protection.
module flash_fe_wrcap
  import flash_fe_pkg::*;
#(
  parameter int AW        = 20,
  parameter int DW        = 16,
  parameter int SECT_BITS = 4,
  parameter int PROT_MODE = 2   // 0: lowest sector, 1: highest, 2: both
) (
  input  logic          clk,
  input  logic          rst,
  input  bus_op_e       op,
  input  logic          word_mode,
  input  logic          wr_prot_n,
  input  logic [AW-1:0] addr_in,
  input  logic [DW-1:0] dq_in,
  output logic          wr_done,
  output logic [DW-1:0] hold_data,
  output logic          cmd_valid,
  output logic [AW:0]   cmd_addr,
  output logic [DW-1:0] cmd_data,
  output logic          cmd_prot
);
  localparam int HALF = DW / 2;

  logic [SECT_BITS-1:0] sect;
  logic                 sect_hit;
  logic                 wr_q;
  logic [AW:0]          hold_addr;
  logic                 hold_prot;

  assign sect = addr_in[AW-1 -: SECT_BITS];

  generate
    if (PROT_MODE == 0) begin : g_prot_low
      assign sect_hit = (sect == '0);
    end else if (PROT_MODE == 1) begin : g_prot_high
      assign sect_hit = (sect == '1);
    end else begin : g_prot_both
      assign sect_hit = (sect == '0) || (sect == '1);
    end
  endgenerate

  // Strobe ended cleanly: last cycle was a write, this one neither write nor reset.
  assign wr_done = wr_q && (op != OP_WRITE) && (op != OP_RESET);

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_q      <= 1'b0;
      hold_addr <= '0;
      hold_data <= '0;
      hold_prot <= 1'b0;
      cmd_valid <= 1'b0;
      cmd_addr  <= '0;
      cmd_data  <= '0;
      cmd_prot  <= 1'b0;
    end else begin
      wr_q      <= (op == OP_WRITE);
      cmd_valid <= wr_done;
      if (op == OP_WRITE) begin
        hold_addr <= word_mode ? {addr_in, 1'b0} : {addr_in, dq_in[DW-1]};
        hold_data <= word_mode ? dq_in : {{(DW-HALF){1'b0}}, dq_in[HALF-1:0]};
        hold_prot <= !wr_prot_n && sect_hit;
      end
      if (wr_done) begin
        cmd_addr <= hold_addr;
        cmd_data <= hold_data;
        cmd_prot <= hold_prot;
      end else begin
        cmd_prot <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/flash_fe_mode.sv
`timescale 1ns/1ps
// Command register; read-array mode after any reset.
module flash_fe_mode #(
  parameter int          CW       = 8,
  parameter logic [CW-1:0] READ_CMD = 8'hF0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          hw_rst_n,
  input  logic          wr_done,
  input  logic [CW-1:0] cmd_byte,
  output logic          read_mode
);
  logic [CW-1:0] cmd_reg;

  always_ff @(posedge clk) begin
    if (rst || !hw_rst_n) cmd_reg <= READ_CMD;
    else if (wr_done)     cmd_reg <= cmd_byte;
  end

  assign read_mode = (cmd_reg == READ_CMD);
endmodule

// File: rtl/flash_fe.sv
`timescale 1ns/1ps
module flash_fe
  import flash_fe_pkg::*;
#(
  parameter int AW        = 20,
  parameter int DW        = 16,
  parameter int SECT_BITS = 4,
  parameter int PROT_MODE = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          chip_en_n,
  input  logic          out_en_n,
  input  logic          wr_en_n,
  input  logic          hw_rst_n,
  input  logic          wr_prot_n,
  input  logic          word_mode,
  input  logic [AW-1:0] addr_in,
  input  logic [DW-1:0] dq_in,
  input  logic [DW-1:0] arr_rdata,
  output logic [AW-1:0] arr_addr,
  output logic [DW-1:0] dq_out,
  output logic          lane_oe_lo,
  output logic          lane_oe_mid,
  output logic          lane_oe_top,
  output logic [2:0]    bus_op,
  output logic          cmd_valid,
  output logic [AW:0]   cmd_addr,
  output logic [DW-1:0] cmd_data,
  output logic          cmd_prot,
  output logic          read_mode
);
  localparam int HALF = DW / 2;

  bus_op_e       op;
  bus_op_e       op_q;
  logic          wr_done;
  logic [DW-1:0] hold_data;

  assign arr_addr = addr_in;

  flash_fe_decode u_decode (
    .chip_en_n (chip_en_n),
    .out_en_n  (out_en_n),
    .wr_en_n   (wr_en_n),
    .hw_rst_n  (hw_rst_n),
    .op        (op)
  );

  flash_fe_lanes #(.DW(DW)) u_lanes (
    .clk       (clk),
    .rst       (rst),
    .op        (op),
    .word_mode (word_mode),
    .byte_hi   (dq_in[DW-1]),
    .arr_rdata (arr_rdata),
    .dq_out    (dq_out),
    .oe_lo     (lane_oe_lo),
    .oe_mid    (lane_oe_mid),
    .oe_top    (lane_oe_top)
  );

  flash_fe_wrcap #(
    .AW(AW), .DW(DW), .SECT_BITS(SECT_BITS), .PROT_MODE(PROT_MODE)
  ) u_wrcap (
    .clk       (clk),
    .rst       (rst),
    .op        (op),
    .word_mode (word_mode),
    .wr_prot_n (wr_prot_n),
    .addr_in   (addr_in),
    .dq_in     (dq_in),
    .wr_done   (wr_done),
    .hold_data (hold_data),
    .cmd_valid (cmd_valid),
    .cmd_addr  (cmd_addr),
    .cmd_data  (cmd_data),
    .cmd_prot  (cmd_prot)
  );

  flash_fe_mode #(.CW(HALF)) u_mode (
    .clk       (clk),
    .rst       (rst),
    .hw_rst_n  (hw_rst_n),
    .wr_done   (wr_done),
    .cmd_byte  (hold_data[HALF-1:0]),
    .read_mode (read_mode)
  );

  always_ff @(posedge clk) begin
    if (rst) op_q <= OP_STANDBY;
    else     op_q <= op;
  end

  assign bus_op = op_q;
endmodule

// File: rtl/flash_fe_chk.sv
`timescale 1ns/1ps
module flash_fe_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          chip_en_n,
  input logic          out_en_n,
  input logic          wr_en_n,
  input logic          hw_rst_n,
  input logic          word_mode,
  input logic [DW-1:0] arr_rdata,
  input logic [DW-1:0] dq_out,
  input logic          lane_oe_lo,
  input logic          lane_oe_mid,
  input logic          lane_oe_top,
  input logic          cmd_valid,
  input logic          cmd_prot,
  input logic          read_mode
);
  p_reset_tristate_r1: assert property (@(posedge clk) disable iff (rst)
    !hw_rst_n |=> (!lane_oe_lo && !lane_oe_mid && !lane_oe_top));

  p_standby_tristate_r2: assert property (@(posedge clk) disable iff (rst)
    (hw_rst_n && chip_en_n) |=> (!lane_oe_lo && !lane_oe_mid && !lane_oe_top));

  p_word_read_r3: assert property (@(posedge clk) disable iff (rst)
    (hw_rst_n && !chip_en_n && !out_en_n && wr_en_n && word_mode)
      |=> (lane_oe_lo && lane_oe_mid && lane_oe_top && dq_out == $past(arr_rdata)));

  p_byte_lanes_r5: assert property (@(posedge clk) disable iff (rst)
    (hw_rst_n && !chip_en_n && !out_en_n && wr_en_n && !word_mode)
      |=> (lane_oe_lo && !lane_oe_mid && !lane_oe_top));

  p_pulse_width_r6: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |=> !cmd_valid);

  p_prot_with_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    !cmd_valid |-> !cmd_prot);

  p_mode_restore_r9: assert property (@(posedge clk) disable iff (rst)
    !hw_rst_n |=> read_mode);

  p_abort_no_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    !hw_rst_n |=> !cmd_valid);
endmodule

bind flash_fe flash_fe_chk #(.DW(DW)) i_flash_fe_chk (
  .clk         (clk),
  .rst         (rst),
  .chip_en_n   (chip_en_n),
  .out_en_n    (out_en_n),
  .wr_en_n     (wr_en_n),
  .hw_rst_n    (hw_rst_n),
  .word_mode   (word_mode),
  .arr_rdata   (arr_rdata),
  .dq_out      (dq_out),
  .lane_oe_lo  (lane_oe_lo),
  .lane_oe_mid (lane_oe_mid),
  .lane_oe_top (lane_oe_top),
  .cmd_valid   (cmd_valid),
  .cmd_prot    (cmd_prot),
  .read_mode   (read_mode)
);

// File: tb/test_flash_fe.sv
`timescale 1ns/1ps
module test_flash_fe;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        chip_en_n = 1'b1, out_en_n = 1'b1, wr_en_n = 1'b1;
  logic        hw_rst_n = 1'b1, wr_prot_n = 1'b1, word_mode = 1'b1;
  logic [19:0] addr_in = '0;
  logic [15:0] dq_in = '0;
  logic [15:0] arr_rdata;
  logic [19:0] arr_addr;
  logic [15:0] dq_out;
  logic        lane_oe_lo, lane_oe_mid, lane_oe_top;
  logic [2:0]  bus_op;
  logic        cmd_valid;
  logic [20:0] cmd_addr;
  logic [15:0] cmd_data;
  logic        cmd_prot, read_mode;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  // Array model: a fixed function of the word address.
  assign arr_rdata = arr_addr[15:0] ^ 16'h5A3C;

  flash_fe i_flash_fe (
    .clk(clk), .rst(rst), .chip_en_n(chip_en_n), .out_en_n(out_en_n),
    .wr_en_n(wr_en_n), .hw_rst_n(hw_rst_n), .wr_prot_n(wr_prot_n),
    .word_mode(word_mode), .addr_in(addr_in), .dq_in(dq_in),
    .arr_rdata(arr_rdata), .arr_addr(arr_addr), .dq_out(dq_out),
    .lane_oe_lo(lane_oe_lo), .lane_oe_mid(lane_oe_mid), .lane_oe_top(lane_oe_top),
    .bus_op(bus_op), .cmd_valid(cmd_valid), .cmd_addr(cmd_addr),
    .cmd_data(cmd_data), .cmd_prot(cmd_prot), .read_mode(read_mode)
  );

  function automatic logic [15:0] model_word(input logic [19:0] a);
    return a[15:0] ^ 16'h5A3C;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic pins(input logic ce, input logic oe, input logic we, input logic hr,
                      input logic wp, input logic wm, input logic [19:0] a, input logic [15:0] d);
    chip_en_n = ce; out_en_n = oe; wr_en_n = we; hw_rst_n = hr;
    wr_prot_n = wp; word_mode = wm; addr_in = a; dq_in = d;
  endtask

  task automatic chk_lanes(input string req, input logic [2:0] exp);
    chk(req, {29'd0, lane_oe_lo, lane_oe_mid, lane_oe_top}, {29'd0, exp});
  endtask

  task automatic t_reset_state();
    tick();
    chk("R11 op", bus_op, 0);
    chk_lanes("R11 lanes", 3'b000);
    chk("R11 valid", cmd_valid, 0);
    chk("R11 read_mode", read_mode, 1);
    rst = 1'b0;
    tick();
  endtask

  task automatic t_word_read();
    for (int i = 0; i < 4; i++) begin
      logic [19:0] a;
      a = 20'h01234 + 20'h1111 * i;
      pins(0, 0, 1, 1, 1, 1, a, 16'hFFFF);
      tick();
      chk("R3 op", bus_op, 1);
      chk_lanes("R3 lanes", 3'b111);
      chk("R3 data", dq_out, model_word(a));
    end
  endtask

  task automatic t_byte_read();
    for (int b = 0; b < 2; b++) begin
      logic [19:0] a;
      logic [15:0] w;
      a = 20'h0A5C3 + b;
      w = model_word(a);
      pins(0, 0, 1, 1, 1, 0, a, {b[0], 15'h7FFF});
      tick();
      chk_lanes("R5 lanes", 3'b100);
      chk("R5 data", dq_out, b[0] ? {8'h00, w[15:8]} : {8'h00, w[7:0]});
    end
  endtask

  task automatic t_out_disable();
    pins(0, 1, 1, 1, 1, 1, 20'h00010, 16'h0);
    tick();
    chk("R4 op both high", bus_op, 3);
    chk_lanes("R4 lanes", 3'b000);
    pins(0, 0, 0, 1, 1, 1, 20'h00010, 16'h0);
    tick();
    chk("R4 op both low", bus_op, 3);
    chk_lanes("R4 lanes both low", 3'b000);
  endtask

  task automatic t_standby();
    pins(1, 0, 0, 1, 1, 1, 20'h00020, 16'h1234);
    tick();
    chk("R2 op", bus_op, 0);
    chk_lanes("R2 lanes", 3'b000);
    tick();
    chk("R2 no write", cmd_valid, 0);
  endtask

  task automatic t_pin_reset();
    pins(0, 0, 1, 0, 1, 1, 20'h00030, 16'h0);
    tick();
    chk("R1 op", bus_op, 4);
    chk_lanes("R1 lanes", 3'b000);
    pins(1, 1, 1, 1, 1, 1, 20'h0, 16'h0);
    tick();
  endtask

  task automatic do_write(input string req, input logic [19:0] a, input logic [15:0] d,
                          input logic wm, input logic wp,
                          input logic [20:0] exp_addr, input logic [15:0] exp_data,
                          input logic exp_prot);
    pins(0, 1, 0, 1, wp, wm, a, d);
    tick();
    chk({req, " write op"}, bus_op, 2);
    tick();
    chk({req, " no early pulse"}, cmd_valid, 0);
    pins(0, 1, 1, 1, 1, 1, a, 16'h0);
    tick();
    chk({req, " pulse"}, cmd_valid, 1);
    chk({req, " addr"}, cmd_addr, exp_addr);
    chk({req, " data"}, cmd_data, exp_data);
    chk({req, " prot"}, cmd_prot, exp_prot);
    tick();
    chk({req, " pulse one cycle"}, cmd_valid, 0);
    pins(1, 1, 1, 1, 1, 1, 20'h0, 16'h0);
    tick();
  endtask

  task automatic t_writes();
    do_write("R6 word", 20'h5_1234, 16'hBEEF, 1, 1, {20'h5_1234, 1'b0}, 16'hBEEF, 0);
    do_write("R7 byte lo", 20'h3_0042, 16'h7F11, 0, 1, {20'h3_0042, 1'b0}, 16'h0011, 0);
    do_write("R7 byte hi", 20'h3_0042, 16'hFF22, 0, 1, {20'h3_0042, 1'b1}, 16'h0022, 0);
  endtask

  task automatic t_protect();
    do_write("R8 sect0 wp", 20'h0_0100, 16'h00F0, 1, 0, {20'h0_0100, 1'b0}, 16'h00F0, 1);
    do_write("R8 sect15 wp", 20'hF_0100, 16'h00F0, 1, 0, {20'hF_0100, 1'b0}, 16'h00F0, 1);
    do_write("R8 sect5 wp", 20'h5_0100, 16'h00F0, 1, 0, {20'h5_0100, 1'b0}, 16'h00F0, 0);
    do_write("R8 sect0 open", 20'h0_0100, 16'h00F0, 1, 1, {20'h0_0100, 1'b0}, 16'h00F0, 0);
  endtask

  task automatic t_mode_reg();
    chk("R9 start", read_mode, 1);
    pins(0, 1, 0, 1, 1, 1, 20'h00555, 16'h0090);
    tick();
    pins(0, 1, 1, 1, 1, 1, 20'h00555, 16'h0);
    tick();
    chk("R9 leave read mode", read_mode, 0);
    pins(0, 1, 0, 1, 1, 1, 20'h00555, 16'h00F0);
    tick();
    pins(0, 1, 1, 1, 1, 1, 20'h00555, 16'h0);
    tick();
    chk("R9 back to read mode", read_mode, 1);
    pins(0, 1, 0, 1, 1, 1, 20'h00555, 16'h0098);
    tick();
    pins(0, 1, 1, 1, 1, 1, 20'h00555, 16'h0);
    tick();
    chk("R9 leave again", read_mode, 0);
    pins(1, 1, 1, 0, 1, 1, 20'h0, 16'h0);
    tick();
    chk("R9 pin reset restores", read_mode, 1);
    pins(1, 1, 1, 1, 1, 1, 20'h0, 16'h0);
    tick();
  endtask

  task automatic t_abort();
    pins(0, 1, 0, 1, 1, 1, 20'h00777, 16'h0012);
    tick();
    tick();
    pins(0, 1, 0, 0, 1, 1, 20'h00777, 16'h0012);
    tick();
    chk("R10 op reset", bus_op, 4);
    chk("R10 no pulse at reset", cmd_valid, 0);
    pins(0, 1, 1, 1, 1, 1, 20'h00777, 16'h0);
    tick();
    chk("R10 no pulse after", cmd_valid, 0);
    tick();
    chk("R10 still none", cmd_valid, 0);
    chk("R10 mode unchanged", read_mode, 1);
    pins(1, 1, 1, 1, 1, 1, 20'h0, 16'h0);
    tick();
  endtask

  initial begin
    t_reset_state();
    t_word_read();
    t_byte_read();
    t_out_disable();
    t_standby();
    t_pin_reset();
    t_writes();
    t_protect();
    t_mode_reg();
    t_abort();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule